// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. A 16-bit counter counts upward once per prescaled tick while the timer is enabled. Software reloads the counter before it runs past 0xFFFF. If the counter wraps, the block latches an overflow flag and asks the system to reset with a pulse that lasts a fixed number of cycles. To program a timeout of N ticks, software loads 65536 minus N.

A write to either register takes effect only when the upper bits of the write data carry that register's own key. Any other write is dropped. A counter write is not applied at once. It stays pending while a busy flag is set, and software waits for that flag to read 0 before it turns the timer on.

Top module: `kwdt_top`

## Requirements
- R1: After reset the count reads 0, the control/status register reads 0 and `rst_req` is low.
- R2: A write to offset 0 whose data bits [31:16] equal 0x5A5A is accepted. The busy flag (control/status bit 5) then reads 1 for exactly 3 cycles. When it clears, the counter holds data bits [15:0].
- R3: A write to offset 4 whose data bits [31:8] equal 0xA5A5A5 is accepted. Bit 7 sets the enable, bits [2:0] set the clock-select index, and bits 6 and 3 are stored and read back with no effect on timing.
- R4: A write is ignored when it carries the wrong key or targets any offset other than 0 or 4. The count, the control bits and the flags stay unchanged.
- R5: While enabled, the counter advances once every D system cycles, where D is 1, 4, 16, 32, 64, 128 or 1024 for clock-select index 0 to 6. The first advance comes D cycles after the enabling write.
- R6: While the enable bit is 0, the count holds its value.
- R7: When an enabled tick finds the count at 0xFFFF, the count wraps to 0, the overflow flag (bit 4) sets, and `rst_req` is high for exactly 4 cycles.
- R8: A keyed control write with bit 4 equal to 0 clears the overflow flag. A keyed control write with bit 4 equal to 1 leaves it set.
- R9: `bus_rdata` is registered. One cycle after an address is presented it returns the count in bits [15:0] with the upper bits 0 (offset 0), or the control/status byte {enable, spare, busy, overflow, spare, select} (offset 4), or 0 for any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data, including the key in the upper bits |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Registered read data |
| rst_req | output | 1 | Reset request raised on counter overflow |

## Verification
A register write takes effect on the edge that samples it. A read returns the state from before the edge at which the address is sampled, so every read in the bench happens one edge after the write it observes.

- Busy reads 1 on the three reads that follow a counter write and 0 on the fourth, and the loaded value is visible from that fourth read on.
- With divisor D, enabling at edge E and disabling at edge E+k leaves exactly floor(k/D) increments. The bench places the disabling write on a counted edge and checks k values on both sides of a multiple of D.
- `rst_req` is sampled just after each edge following the enabling write. From a start of 0xFFFD at divisor 1 it must be high after edges 3 through 6 and low after edges 1, 2 and 7.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [15:0] CNT_KEY  = 16'h5A5A;
  localparam logic [23:0] CSR_KEY  = 24'hA5A5A5;
  localparam int          OFF_CNT  = 0;
  localparam int          OFF_CSR  = 4;
  localparam int          BIT_EN   = 7;
  localparam int          BIT_BUSY = 5;
  localparam int          BIT_OVF  = 4;

  function automatic int unsigned div_of(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 16;
      3'd3:    return 32;
      3'd4:    return 64;
      3'd5:    return 128;
      default: return 1024;
    endcase
  endfunction
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              we,
  input  logic              ovf_set,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wval,
  output logic              en,
  output logic [2:0]        sel,
  output logic [1:0]        spare,
  output logic              ovf
);
  logic csr_wr;

  always_comb begin
    cnt_wr   = we && (addr == ADDR_W'(OFF_CNT)) && (wdata[31:16] == CNT_KEY);
    csr_wr   = we && (addr == ADDR_W'(OFF_CSR)) && (wdata[31:8] == CSR_KEY);
    cnt_wval = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= 1'b0;
      sel   <= 3'd0;
      spare <= 2'b00;
      ovf   <= 1'b0;
    end else begin
      if (csr_wr) begin
        en    <= wdata[BIT_EN];
        sel   <= wdata[2:0];
        spare <= {wdata[6], wdata[3]};
      end
      if (ovf_set)
        ovf <= 1'b1;
      else if (csr_wr && !wdata[BIT_OVF] && !wdata[BIT_BUSY])
        ovf <= 1'b0;
      else if (csr_wr && !wdata[BIT_OVF])
        ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
  import kwdt_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] lim;

  always_comb begin
    lim  = PRE_W'(div_of(sel) - 1);
    tick = en && (pcnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !en)
      pcnt <= '0;
    else if (tick)
      pcnt <= '0;
    else
      pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W     = 16,
  parameter int BUSY_CYC  = 3,
  parameter int PULSE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wval,
  output logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             wrap,
  output logic             rst_req
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [BW-1:0]    busy_cnt;
  logic [CNT_W-1:0] pend;
  logic [PW-1:0]    pulse_cnt;
  logic             load;

  always_comb begin
    busy    = (busy_cnt != '0);
    load    = (busy_cnt == BW'(1)) && !wr;
    wrap    = tick && !load && (count == '1);
    rst_req = (pulse_cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      pend     <= '0;
    end else if (wr) begin
      busy_cnt <= BW'(BUSY_CYC);
      pend     <= wval;
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (load)
      count <= pend;
    else if (tick)
      count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      pulse_cnt <= '0;
    else if (wrap)
      pulse_cnt <= PW'(PULSE_CYC);
    else if (pulse_cnt != '0)
      pulse_cnt <= pulse_cnt - 1'b1;
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 10,
  parameter int BUSY_CYC  = 3,
  parameter int PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  logic             cnt_wr, en_w, ovf_w, tick_w, busy_w, wrap_w;
  logic [CNT_W-1:0] cnt_wval, count_w;
  logic [2:0]       sel_w;
  logic [1:0]       spare_w;
  logic [7:0]       csr_byte;

  kwdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .ovf_set(wrap_w), .cnt_wr(cnt_wr), .cnt_wval(cnt_wval), .en(en_w),
    .sel(sel_w), .spare(spare_w), .ovf(ovf_w)
  );

  kwdt_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst(rst), .en(en_w), .sel(sel_w), .tick(tick_w)
  );

  kwdt_counter #(.CNT_W(CNT_W), .BUSY_CYC(BUSY_CYC), .PULSE_CYC(PULSE_CYC)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick_w), .wr(cnt_wr), .wval(cnt_wval),
    .count(count_w), .busy(busy_w), .wrap(wrap_w), .rst_req(rst_req)
  );

  assign csr_byte = {en_w, spare_w[1], busy_w, ovf_w, spare_w[0], sel_w};

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_addr == ADDR_W'(OFF_CNT))
      bus_rdata <= 32'(count_w);
    else if (bus_addr == ADDR_W'(OFF_CSR))
      bus_rdata <= {24'h0, csr_byte};
    else
      bus_rdata <= '0;
  end
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
  import kwdt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 16,
  parameter int PULSE_CYC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic              rst_req,
  input logic [CNT_W-1:0]  count,
  input logic              busy,
  input logic              en,
  input logic              tick,
  input logic              wrap,
  input logic              ovf
);
  int run_len;
  always_ff @(posedge clk) begin
    if (rst)          run_len <= 0;
    else if (rst_req) run_len <= run_len + 1;
    else              run_len <= 0;
  end

  assert_cnt_key_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFF_CNT) && bus_wdata[31:16] == CNT_KEY) |=> busy);

  assert_bad_key_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFF_CNT) && bus_wdata[31:16] != CNT_KEY && !busy) |=> !busy);

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(tick) && !$past(busy)) |-> count == CNT_W'($past(count) + 1'b1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && !$past(busy)) |-> $stable(count));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    $past(wrap) |-> (ovf && rst_req && count == '0));

  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (rst)
    run_len <= PULSE_CYC);

  assert_read_upper_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(OFF_CNT)) |-> bus_rdata[31:16] == 16'h0);
endmodule

bind kwdt_top kwdt_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .rst_req(rst_req), .count(count_w), .busy(busy_w),
  .en(en_w), .tick(tick_w), .wrap(wrap_w), .ovf(ovf_w)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  kwdt_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    v = bus_rdata;
  endtask

  task automatic load0(input logic [15:0] val);
    wr(4'd0, {16'h5A5A, val});
    repeat (4) @(posedge clk);
  endtask

  function automatic int divisor(input int idx);
    case (idx)
      0: return 1;    1: return 4;   2: return 16;  3: return 32;
      4: return 64;   5: return 128; default: return 1024;
    endcase
  endfunction

  task automatic span(input int idx, input int k);
    logic [31:0] v;
    load0(16'h0000);
    wr(4'd4, 32'hA5A5A580 | 32'(idx));
    repeat (k - 1) @(posedge clk);
    wr(4'd4, 32'hA5A5A500 | 32'(idx));
    rd(4'd0, v);
    chk("R5", v, 32'(k / divisor(idx)));
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    rd(4'd0, v); chk("R1", v, 32'h0);
    rd(4'd4, v); chk("R1", v, 32'h0);
    chk("R1", 32'(rst_req), 32'h0);

    // R2 busy length and load
    wr(4'd0, 32'h5A5A1234);
    for (int i = 0; i < 3; i++) begin rd(4'd4, v); chk("R2", v, 32'h20); end
    rd(4'd4, v); chk("R2", v, 32'h00);
    rd(4'd0, v); chk("R2", v, 32'h1234);
    rd(4'd0, v); chk("R9", v[31:16], 32'h0);

    // R4 wrong keys and unmapped offset
    wr(4'd0, 32'h5A5B4321);
    rd(4'd4, v); chk("R4", v, 32'h00);
    repeat (4) @(posedge clk);
    rd(4'd0, v); chk("R4", v, 32'h1234);
    wr(4'd4, 32'hA5A5A480);
    wr(4'd8, 32'hA5A5A580);
    repeat (20) @(posedge clk);
    rd(4'd4, v); chk("R4", v, 32'h00);
    rd(4'd0, v); chk("R4", v, 32'h1234);
    rd(4'd8, v); chk("R9", v, 32'h0);

    // R3 keyed control write
    wr(4'd4, 32'hA5A5A5CB);
    rd(4'd4, v); chk("R3", v, 32'hCB);
    wr(4'd4, 32'hA5A5A503);
    rd(4'd4, v); chk("R3", v, 32'h03);

    // R5 prescale sweep, R6 hold while disabled
    for (int idx = 0; idx < 7; idx++) begin
      span(idx, 3 * divisor(idx) + divisor(idx) / 2);
      span(idx, 3 * divisor(idx) - 1);
    end
    load0(16'h0777);
    repeat (50) @(posedge clk);
    rd(4'd0, v); chk("R6", v, 32'h0777);

    // R7 overflow and reset request
    load0(16'hFFFD);
    wr(4'd4, 32'hA5A5A580);
    for (int j = 1; j <= 7; j++) begin
      @(posedge clk); #1;
      chk("R7", 32'(rst_req), (j >= 3 && j <= 6) ? 32'h1 : 32'h0);
    end
    rd(4'd4, v); chk("R7", v, 32'h90);

    // R8 overflow clear rules
    wr(4'd4, 32'hA5A5A510);
    rd(4'd4, v); chk("R8", v, 32'h10);
    wr(4'd4, 32'hA5A5A500);
    rd(4'd4, v); chk("R8", v, 32'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule